// File: doc/BRIEF.md
# Receive Descriptor Chain Walker

This block follows a chain of receive descriptors held in system memory and fills one descriptor for each packet that the receive datapath reports as finished. On each completion strobe it latches the packet's status, byte count, buffer pointer and sequence value. It writes them into the current descriptor through a memory master port, then reads that descriptor's link field. Whether it hands the descriptor to the host or keeps it depends on the link.

The least significant bit of a link value marks the end of the chain. A link with this bit clear is loaded as the new current-descriptor address. The walker then writes zero into the descriptor's in-use word and pulses the packet-received interrupt. A link with the bit set makes the walker keep ownership of the descriptor, and it remembers where that link word sits. At each later completion it reads that link word again. While the flag is still set, the new packet is withheld and nothing is written. Once the host has appended descriptors and cleared the flag, the walker releases the held descriptor, signals it, and stores the new packet in the appended descriptor.

The host sets the first descriptor address with a load strobe. The register keeps whatever value was loaded, including bit 0, and the flag bit is removed only where an address goes onto the memory port.

Top module: `rxw_walker`

## Requirements
- R1: Bit 0 of every memory request address is 0, even when the current-descriptor register holds an odd value; `cur_desc_addr` keeps bit 0 exactly as it was loaded.
- R2: For a packet, the walker writes status, byte count, buffer pointer bits 15:0, buffer pointer bits 31:16 and sequence, in that order, at byte offsets 0, 4, 8, 12 and 16 from the masked descriptor base. It then reads the link at offset 20, and the in-use word sits at offset 24.
- R3: Every write is a full 32-bit word, with the 16-bit field in bits 15:0 and bits 31:16 forced to zero.
- R4: If the link read has bit 0 clear, the walker writes 0 to the in-use word, loads `cur_desc_addr` with the link value, and raises one interrupt.
- R5: If the link read has bit 0 set, the walker does not write the in-use word, raises no interrupt and leaves `cur_desc_addr` unchanged. `link_field_addr` holds the address of that link word.
- R6: While a descriptor is held, a new packet makes the walker re-read the held link word. If bit 0 is still set, the packet is withheld: no write, no interrupt, and `cur_desc_addr` is unchanged.
- R7: If the re-read link has bit 0 clear, the walker writes 0 to the held in-use word (link address + 4) and raises an interrupt. It then loads `cur_desc_addr` with the link value and writes the new packet's fields into that descriptor.
- R8: A request held while `mem_req_ready` is low keeps its address and direction until it is accepted, and results do not depend on stalls.
- R9: After reset no request is valid, `irq_pkt` is low and `cur_desc_addr` is 0.
- R10: `irq_pkt` is a single-cycle pulse per released descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load the current-descriptor register and drop any hold |
| cfg_desc_addr | input | 16 | Value loaded by cfg_load |
| pkt_done | input | 1 | One-cycle packet completion strobe, taken when the walker is idle |
| pkt_status | input | 16 | Receive status of the completed packet |
| pkt_count | input | 16 | Byte count of the completed packet |
| pkt_buf_addr | input | 32 | Buffer pointer of the completed packet |
| pkt_seq | input | 16 | Sequence value of the completed packet |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 16 | Byte address, bit 0 always 0 |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| irq_pkt | output | 1 | Packet-received interrupt pulse |
| cur_desc_addr | output | 16 | Current-descriptor register |
| link_field_addr | output | 16 | Address of the last link word read |

## Verification
The walker is exercised with a chain whose first link points onward, then with a link that carries the end flag, then with a repeat reception while the flag is still set, and finally after the host clears the flag. The onward link separates a correct hand-off from a missing in-use write. The flagged link shows whether the descriptor is really kept. The repeat reception shows whether the walker re-reads the old link rather than walking on. The cleared link checks both the release write and the interrupt ordering. An odd starting address shows that masking applies to the memory address and not to the register, and a pseudo-random ready pattern shows that stalls do not change any result.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    localparam int FLD_W      = 16;
    localparam int WORD_BYTES = 4;

    typedef enum logic [2:0] {
        F_STATUS = 3'd0,
        F_COUNT  = 3'd1,
        F_BUF_LO = 3'd2,
        F_BUF_HI = 3'd3,
        F_SEQ    = 3'd4,
        F_LINK   = 3'd5,
        F_INUSE  = 3'd6
    } fld_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HRD,
        S_HWT,
        S_HREL,
        S_WR,
        S_LRD,
        S_LWT,
        S_INUSE
    } st_e;

    typedef struct packed {
        logic [FLD_W-1:0] status;
        logic [FLD_W-1:0] count;
        logic [FLD_W-1:0] buf_lo;
        logic [FLD_W-1:0] buf_hi;
        logic [FLD_W-1:0] seq;
    } pkt_info_t;

    typedef struct packed {
        logic valid;
        logic write;
        fld_e fld;
        logic from_link;
    } mreq_t;

    function automatic logic [FLD_W-1:0] fld_off(fld_e f);
        return FLD_W'(int'(f) * WORD_BYTES);
    endfunction

    function automatic logic [FLD_W-1:0] addr_of(logic [FLD_W-1:0] v);
        return {v[FLD_W-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
    import rxw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pkt_done,
    input  pkt_info_t info_in,
    input  logic      held,
    input  logic      mem_ready,
    input  logic      rsp_valid,
    input  logic      rsp_eol,
    output mreq_t     req,
    output pkt_info_t info_q,
    output logic      cap_next,
    output logic      adv,
    output logic      set_llfa,
    output logic      set_held,
    output logic      irq
);

    st_e  state;
    fld_e fld;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            fld    <= F_STATUS;
            irq    <= 1'b0;
            info_q <= '0;
        end else begin
            irq <= 1'b0;
            unique case (state)
                S_IDLE: if (pkt_done) begin
                    info_q <= info_in;
                    fld    <= F_STATUS;
                    state  <= held ? S_HRD : S_WR;
                end
                S_HRD:  if (mem_ready) state <= S_HWT;
                S_HWT:  if (rsp_valid) state <= rsp_eol ? S_IDLE : S_HREL;
                S_HREL: if (mem_ready) begin
                    irq   <= 1'b1;
                    fld   <= F_STATUS;
                    state <= S_WR;
                end
                S_WR:   if (mem_ready) begin
                    if (fld == F_SEQ) state <= S_LRD;
                    else              fld   <= fld_e'(fld + 3'd1);
                end
                S_LRD:  if (mem_ready) state <= S_LWT;
                S_LWT:  if (rsp_valid) state <= rsp_eol ? S_IDLE : S_INUSE;
                S_INUSE: if (mem_ready) begin
                    irq   <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req = '{valid: 1'b0, write: 1'b0, fld: F_STATUS, from_link: 1'b0};
        unique case (state)
            S_HRD:   req = '{valid: 1'b1, write: 1'b0, fld: F_LINK,  from_link: 1'b1};
            S_HREL:  req = '{valid: 1'b1, write: 1'b1, fld: F_INUSE, from_link: 1'b1};
            S_WR:    req = '{valid: 1'b1, write: 1'b1, fld: fld,     from_link: 1'b0};
            S_LRD:   req = '{valid: 1'b1, write: 1'b0, fld: F_LINK,  from_link: 1'b0};
            S_INUSE: req = '{valid: 1'b1, write: 1'b1, fld: F_INUSE, from_link: 1'b0};
            default: ;
        endcase
    end

    assign cap_next = ((state == S_HWT) || (state == S_LWT)) && rsp_valid && !rsp_eol;
    assign adv      = ((state == S_HREL) || (state == S_INUSE)) && mem_ready;
    assign set_llfa = (state == S_LRD) && mem_ready;
    assign set_held = (state == S_LWT) && rsp_valid && rsp_eol;

endmodule

// File: rtl/rxw_regs.sv
module rxw_regs
    import rxw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [FLD_W-1:0] cfg_val,
    input  logic [FLD_W-1:0] rsp_link,
    input  logic             cap_next,
    input  logic             adv,
    input  logic             set_llfa,
    input  logic             set_held,
    output logic [FLD_W-1:0] cur_desc,
    output logic [FLD_W-1:0] llfa,
    output logic             held
);

    logic [FLD_W-1:0] nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_desc <= '0;
            llfa     <= '0;
            nxt      <= '0;
            held     <= 1'b0;
        end else begin
            if (cap_next) nxt  <= rsp_link;
            if (set_llfa) llfa <= addr_of(cur_desc) + fld_off(F_LINK);
            if (cfg_load) begin
                cur_desc <= cfg_val;
                held     <= 1'b0;
            end else if (adv) begin
                cur_desc <= nxt;
                held     <= 1'b0;
            end else if (set_held) begin
                held <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxw_mux.sv
module rxw_mux
    import rxw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  mreq_t             req,
    input  pkt_info_t         info,
    input  logic [FLD_W-1:0]  cur_desc,
    input  logic [FLD_W-1:0]  llfa,
    output logic [FLD_W-1:0]  addr,
    output logic [DATA_W-1:0] wdata
);

    localparam int PAD_W = DATA_W - FLD_W;

    logic [FLD_W-1:0] base;
    logic [FLD_W-1:0] fv;

    always_comb begin
        if (req.from_link) base = addr_of(llfa) - fld_off(F_LINK);
        else               base = addr_of(cur_desc);
        addr = base + fld_off(req.fld);
    end

    always_comb begin
        unique case (req.fld)
            F_STATUS: fv = info.status;
            F_COUNT:  fv = info.count;
            F_BUF_LO: fv = info.buf_lo;
            F_BUF_HI: fv = info.buf_hi;
            F_SEQ:    fv = info.seq;
            default:  fv = '0;
        endcase
        wdata = {{PAD_W{1'b0}}, fv};
    end

endmodule

// File: rtl/rxw_walker.sv
module rxw_walker
    import rxw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_load,
    input  logic [FLD_W-1:0]     cfg_desc_addr,
    input  logic                 pkt_done,
    input  logic [FLD_W-1:0]     pkt_status,
    input  logic [FLD_W-1:0]     pkt_count,
    input  logic [2*FLD_W-1:0]   pkt_buf_addr,
    input  logic [FLD_W-1:0]     pkt_seq,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic                 mem_req_write,
    output logic [FLD_W-1:0]     mem_req_addr,
    output logic [DATA_W-1:0]    mem_req_wdata,
    input  logic                 mem_rsp_valid,
    input  logic [DATA_W-1:0]    mem_rsp_rdata,
    output logic                 irq_pkt,
    output logic [FLD_W-1:0]     cur_desc_addr,
    output logic [FLD_W-1:0]     link_field_addr
);

    pkt_info_t info_in, info_q;
    mreq_t     req;
    logic      held, cap_next, adv, set_llfa, set_held;
    logic      unused_rsp_hi;

    assign info_in = '{status: pkt_status, count: pkt_count,
                       buf_lo: pkt_buf_addr[FLD_W-1:0],
                       buf_hi: pkt_buf_addr[2*FLD_W-1:FLD_W],
                       seq: pkt_seq};
    assign unused_rsp_hi = ^mem_rsp_rdata[DATA_W-1:FLD_W];

    rxw_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pkt_done  (pkt_done),
        .info_in   (info_in),
        .held      (held),
        .mem_ready (mem_req_ready),
        .rsp_valid (mem_rsp_valid),
        .rsp_eol   (mem_rsp_rdata[0]),
        .req       (req),
        .info_q    (info_q),
        .cap_next  (cap_next),
        .adv       (adv),
        .set_llfa  (set_llfa),
        .set_held  (set_held),
        .irq       (irq_pkt)
    );

    rxw_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load),
        .cfg_val  (cfg_desc_addr),
        .rsp_link (mem_rsp_rdata[FLD_W-1:0]),
        .cap_next (cap_next),
        .adv      (adv),
        .set_llfa (set_llfa),
        .set_held (set_held),
        .cur_desc (cur_desc_addr),
        .llfa     (link_field_addr),
        .held     (held)
    );

    rxw_mux #(.DATA_W(DATA_W)) u_mux (
        .req      (req),
        .info     (info_q),
        .cur_desc (cur_desc_addr),
        .llfa     (link_field_addr),
        .addr     (mem_req_addr),
        .wdata    (mem_req_wdata)
    );

    assign mem_req_valid = req.valid;
    assign mem_req_write = req.write;

endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
    parameter int DATA_W = 32,
    parameter int FLD_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_load,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [FLD_W-1:0]  mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic              irq_pkt,
    input logic [FLD_W-1:0]  cur_desc_addr
);

    a_r1_addr_even: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !mem_req_addr[0]);

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (mem_req_wdata[DATA_W-1:FLD_W] == '0));

    a_r4_cur_moves_with_irq: assert property (@(posedge clk) disable iff (rst)
        (cur_desc_addr != $past(cur_desc_addr)) |-> (irq_pkt || $past(cfg_load)));

    a_r7_irq_after_release_write: assert property (@(posedge clk) disable iff (rst)
        irq_pkt |-> $past(mem_req_valid && mem_req_ready && mem_req_write
                          && (mem_req_wdata == '0)));

    a_r8_hold_request: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    a_r10_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_pkt |=> !irq_pkt);

endmodule

bind rxw_walker rxw_checker #(.DATA_W(DATA_W), .FLD_W(rxw_pkg::FLD_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_load      (cfg_load),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .irq_pkt       (irq_pkt),
    .cur_desc_addr (cur_desc_addr)
);

// File: tb/tb_rxw_walker.sv
module tb_rxw_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_desc_addr = '0;
    logic        pkt_done = 1'b0;
    logic [15:0] pkt_status = '0, pkt_count = '0, pkt_seq = '0;
    logic [31:0] pkt_buf_addr = '0;
    logic        mem_req_valid, mem_req_write, mem_req_ready;
    logic [15:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;
    logic        irq_pkt;
    logic [15:0] cur_desc_addr, link_field_addr;

    always #2 clk = ~clk;

    rxw_walker dut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_desc_addr(cfg_desc_addr),
        .pkt_done(pkt_done), .pkt_status(pkt_status), .pkt_count(pkt_count),
        .pkt_buf_addr(pkt_buf_addr), .pkt_seq(pkt_seq),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .irq_pkt(irq_pkt),
        .cur_desc_addr(cur_desc_addr), .link_field_addr(link_field_addr)
    );

    // memory model
    logic [31:0] mem [0:63];
    logic [15:0] wlog [0:63];
    int          wcnt = 0;
    logic        stall_en = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic        poke_en = 1'b0;
    logic [5:0]  poke_idx = '0;
    logic [31:0] poke_val = '0;
    int          irq_hi = 0, irq_rise = 0;
    logic        irq_prev = 1'b0;

    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_req_ready <= stall_en ? lfsr[0] : 1'b1;
        mem_rsp_valid <= 1'b0;
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'hFFFF_FFFF;
            mem_req_ready <= 1'b1;
        end else begin
            if (poke_en) mem[poke_idx] <= poke_val;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    mem[mem_req_addr[7:2]] <= mem_req_wdata;
                    wlog[wcnt[5:0]] <= mem_req_addr;
                    wcnt <= wcnt + 1;
                end else begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_rdata <= mem[mem_req_addr[7:2]];
                end
            end
            if (irq_pkt) irq_hi <= irq_hi + 1;
            if (irq_pkt && !irq_prev) irq_rise <= irq_rise + 1;
            irq_prev <= irq_pkt;
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic poke(int idx, logic [31:0] v);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = 6'(idx); poke_val = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic send_pkt(logic [15:0] st, logic [15:0] cnt, logic [31:0] bp, logic [15:0] sq);
        @(negedge clk);
        pkt_done = 1'b1; pkt_status = st; pkt_count = cnt; pkt_buf_addr = bp; pkt_seq = sq;
        @(negedge clk);
        pkt_done = 1'b0;
        repeat (100) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9", "req valid", 32'(mem_req_valid), 0);
        check("R9", "irq", 32'(irq_pkt), 0);
        check("R9", "cur desc", 32'(cur_desc_addr), 0);
    endtask

    // odd start address, onward link 0x40
    task automatic t_masked_first();
        int w0;
        @(negedge clk); cfg_load = 1'b1; cfg_desc_addr = 16'h0001;
        @(negedge clk); cfg_load = 1'b0;
        check("R1", "cur keeps bit0", 32'(cur_desc_addr), 32'h0001);
        w0 = wcnt;
        send_pkt(16'h1234, 16'h003C, 32'h1357_2468, 16'h0507);
        check("R2", "write count", 32'(wcnt - w0), 6);
        check("R2", "order status", 32'(wlog[w0]), 32'h00);
        check("R2", "order count",  32'(wlog[w0+1]), 32'h04);
        check("R2", "order buf lo", 32'(wlog[w0+2]), 32'h08);
        check("R2", "order buf hi", 32'(wlog[w0+3]), 32'h0C);
        check("R2", "order seq",    32'(wlog[w0+4]), 32'h10);
        check("R1", "in-use addr",  32'(wlog[w0+5]), 32'h18);
        check("R3", "status word", mem[0], 32'h0000_1234);
        check("R3", "buf hi word", mem[3], 32'h0000_1357);
        check("R2", "buf lo word", mem[2], 32'h0000_2468);
        check("R2", "seq word",    mem[4], 32'h0000_0507);
        check("R4", "in-use cleared", mem[6], 0);
        check("R4", "cur follows link", 32'(cur_desc_addr), 32'h0040);
        check("R4", "irq count", 32'(irq_rise), 1);
    endtask

    task automatic t_normal_stalled();
        stall_en = 1'b1;
        send_pkt(16'h2001, 16'h0100, 32'h0000_0200, 16'h0608);
        check("R8", "count word", mem[17], 32'h0000_0100);
        check("R8", "status word", mem[16], 32'h0000_2001);
        check("R4", "in-use cleared", mem[22], 0);
        check("R4", "cur follows link", 32'(cur_desc_addr), 32'h0080);
        check("R4", "irq count", 32'(irq_rise), 2);
    endtask

    task automatic t_hold();
        int w0;
        w0 = wcnt;
        send_pkt(16'h3003, 16'h0040, 32'h0000_0300, 16'h0709);
        check("R5", "write count", 32'(wcnt - w0), 5);
        check("R5", "status word", mem[32], 32'h0000_3003);
        check("R5", "in-use untouched", mem[38], 32'hFFFF_FFFF);
        check("R5", "cur unchanged", 32'(cur_desc_addr), 32'h0080);
        check("R5", "no irq", 32'(irq_rise), 2);
        check("R5", "link addr", 32'(link_field_addr), 32'h0094);
    endtask

    task automatic t_withhold();
        int w0;
        w0 = wcnt;
        send_pkt(16'h4004, 16'h0044, 32'h0000_0400, 16'h080A);
        check("R6", "no writes", 32'(wcnt - w0), 0);
        check("R6", "held status kept", mem[32], 32'h0000_3003);
        check("R6", "cur unchanged", 32'(cur_desc_addr), 32'h0080);
        check("R6", "no irq", 32'(irq_rise), 2);
    endtask

    task automatic t_resume();
        int w0;
        poke(37, 32'h0000_00C0);
        w0 = wcnt;
        send_pkt(16'h5005, 16'h0048, 32'h0000_0500, 16'h090B);
        check("R7", "write count", 32'(wcnt - w0), 6);
        check("R7", "release first", 32'(wlog[w0]), 32'h0098);
        check("R7", "then new status", 32'(wlog[w0+1]), 32'h00C0);
        check("R7", "held in-use cleared", mem[38], 0);
        check("R7", "new status word", mem[48], 32'h0000_5005);
        check("R7", "new seq word", mem[52], 32'h0000_090B);
        check("R7", "new in-use kept", mem[54], 32'hFFFF_FFFF);
        check("R7", "cur moved", 32'(cur_desc_addr), 32'h00C0);
        check("R7", "irq count", 32'(irq_rise), 3);
        check("R10", "irq high cycles", 32'(irq_hi), 32'(irq_rise));
    endtask

    logic done = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        poke(5,  32'h0000_0040);
        poke(21, 32'h0000_0080);
        poke(37, 32'h0000_0001);
        poke(53, 32'h0000_00E1);
        t_masked_first();
        t_normal_stalled();
        t_hold();
        t_withhold();
        t_resume();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule